// File: doc/BRIEF.md
# Vector Compare Into Mask Unit

This unit compares two 512-bit integer vectors lane by lane and packs the outcome into a bit mask, one bit per lane. It is meant for the execute stage of a SIMD datapath.

The lane width can be 8, 16, 32 or 64 bits. Each compare can be signed or unsigned. A 3-bit predicate code picks one of eight relations, and two of those codes give a constant result. A qualifying mask then limits which result bits may be set. The qualified result is registered and reported one cycle after the request, together with a one-cycle valid strobe.

All lanes are evaluated in parallel for every lane width. The width selector picks one of the four packed results before the qualifier is applied.

Top module: `vcmp_mask_unit`

## Requirements
- R1: `pred_i` selects the relation between lane a and lane b. Code 0 is a==b, 1 is a<b, 2 is a<=b, 4 is a!=b, 5 is a>=b and 6 is a>b.
- R2: Code 3 gives 0 for every lane and code 7 gives 1 for every lane, before qualification.
- R3: With `signed_i`=1 the lanes are compared as two's-complement numbers. With `signed_i`=0 they are compared as unsigned numbers.
- R4: `size_i` selects the lane width: 0 is 8 bits (64 lanes), 1 is 16 bits (32 lanes), 2 is 32 bits (16 lanes) and 3 is 64 bits (8 lanes).
- R5: The result for lane i lands in mask bit i. Lane 0 is the least significant lane-wide slice of each source vector.
- R6: Mask bits at or above the active lane count are 0.
- R7: A lane whose `qual_mask_i` bit is 0 yields 0, whatever the relation gives.
- R8: `valid_o` pulses high for exactly one cycle, one clock edge after a cycle with `valid_i` high. `mask_o` carries that request's result in the same cycle.
- R9: Reset clears `mask_o` and `valid_o`. A cycle without `valid_i` leaves `mask_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector |
| size_i | input | 2 | Lane width code |
| signed_i | input | 1 | 1 selects a signed compare |
| pred_i | input | 3 | Predicate code |
| qual_mask_i | input | 64 | Qualifying mask, bit i covers lane i |
| valid_o | output | 1 | Result strobe |
| mask_o | output | 64 | Registered result mask |

## Verification
Every result goes through a single register stage. The `mask_o` and `valid_o` values for a request are therefore due in the cycle after the clock edge that samples `valid_i`.

The bench applies each request at a falling edge and drops `valid_i` at the next falling edge. At that point it checks `mask_o` and `valid_o` against its own model. One cycle later it checks that `valid_o` has fallen and that `mask_o` held its value.

Directed cases check lane placement, clearing of the unused bits, gating by the qualifier and extreme signed values, each at the same fixed offset.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_LT    = 3'd1,
    PRED_LE    = 3'd2,
    PRED_NEVER = 3'd3,
    PRED_NE    = 3'd4,
    PRED_GE    = 3'd5,
    PRED_GT    = 3'd6,
    PRED_ALWAYS = 3'd7
  } cmp_pred_e;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B64 = 2'd3
  } lane_size_e;

  localparam int unsigned NUM_SIZES = 4;

  function automatic logic pred_eval(cmp_pred_e pred, logic eq, logic lt);
    logic r;
    unique case (pred)
      PRED_EQ:     r = eq;
      PRED_LT:     r = lt;
      PRED_LE:     r = lt | eq;
      PRED_NEVER:  r = 1'b0;
      PRED_NE:     r = ~eq;
      PRED_GE:     r = ~lt;
      PRED_GT:     r = ~(lt | eq);
      default:     r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vcmp_lane_cmp.sv
module vcmp_lane_cmp #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              [LANE_W-1:0] a_i,
  input  logic              [LANE_W-1:0] b_i,
  input  logic                           signed_i,
  input  vcmp_pkg::cmp_pred_e            pred_i,
  output logic                           hit_o
);
  logic [LANE_W-1:0] a_k, b_k;
  logic eq, lt;

  // flipping the sign bit maps two's complement order onto unsigned order
  always_comb begin
    a_k = a_i;
    b_k = b_i;
    a_k[LANE_W-1] = a_i[LANE_W-1] ^ signed_i;
    b_k[LANE_W-1] = b_i[LANE_W-1] ^ signed_i;
    eq = (a_i == b_i);
    lt = (a_k < b_k);
    hit_o = vcmp_pkg::pred_eval(pred_i, eq, lt);
  end
endmodule

// File: rtl/vcmp_size_bank.sv
module vcmp_size_bank #(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned N_LANES = VEC_W / LANE_W
) (
  input  logic [VEC_W-1:0]      src_a_i,
  input  logic [VEC_W-1:0]      src_b_i,
  input  logic                  signed_i,
  input  vcmp_pkg::cmp_pred_e   pred_i,
  output logic [N_LANES-1:0]    hit_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    vcmp_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
      .a_i      (src_a_i[l*LANE_W +: LANE_W]),
      .b_i      (src_b_i[l*LANE_W +: LANE_W]),
      .signed_i (signed_i),
      .pred_i   (pred_i),
      .hit_o    (hit_o[l])
    );
  end
endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit #(
  parameter int unsigned VEC_W = 512,
  localparam int unsigned MASK_W = VEC_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [2:0]        pred_i,
  input  logic [MASK_W-1:0] qual_mask_i,
  output logic              valid_o,
  output logic [MASK_W-1:0] mask_o
);
  import vcmp_pkg::*;

  cmp_pred_e   pred;
  logic [MASK_W-1:0] bank_hits [NUM_SIZES];
  logic [MASK_W-1:0] masked_d;

  assign pred = cmp_pred_e'(pred_i);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned LW = 8 << g;
    localparam int unsigned NL = VEC_W / LW;
    logic [NL-1:0] hits;
    vcmp_size_bank #(.VEC_W(VEC_W), .LANE_W(LW)) u_bank (
      .src_a_i  (src_a_i),
      .src_b_i  (src_b_i),
      .signed_i (signed_i),
      .pred_i   (pred),
      .hit_o    (hits)
    );
    // upper bits zero-filled: inactive lanes never set
    assign bank_hits[g] = MASK_W'(hits);
  end

  assign masked_d = bank_hits[size_i] & qual_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) mask_o <= masked_d;
    end
  end
endmodule

// File: rtl/vcmp_mask_unit_chk.sv
module vcmp_mask_unit_chk #(
  parameter int unsigned VEC_W = 512,
  localparam int unsigned MASK_W = VEC_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        size_i,
  input logic [2:0]        pred_i,
  input logic [MASK_W-1:0] qual_mask_i,
  input logic              valid_o,
  input logic [MASK_W-1:0] mask_o
);
  function automatic logic [MASK_W-1:0] active_bits(logic [1:0] sz);
    return {MASK_W{1'b1}} >> (MASK_W - (MASK_W >> sz));
  endfunction

  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R6
  inactive_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mask_o & ~active_bits($past(size_i))) == '0);

  // R7
  qual_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mask_o & ~$past(qual_mask_i)) == '0);

  // R2
  never_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(pred_i) == 3'd3) |-> mask_o == '0);

  // R2
  always_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(pred_i) == 3'd7) |->
      mask_o == ($past(qual_mask_i) & active_bits($past(size_i))));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(mask_o));
endmodule

bind vcmp_mask_unit vcmp_mask_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .size_i      (size_i),
  .pred_i      (pred_i),
  .qual_mask_i (qual_mask_i),
  .valid_o     (valid_o),
  .mask_o      (mask_o)
);

// File: tb/vcmp_mask_unit_tb.sv
module vcmp_mask_unit_tb_top;
  localparam int unsigned VEC_W  = 512;
  localparam int unsigned MASK_W = VEC_W / 8;
  localparam logic [31:0] SEEDS [8] = '{
    32'h1234_5678, 32'h9e37_79b9, 32'hdead_beef, 32'h0bad_f00d,
    32'hc001_d00d, 32'h7fff_0001, 32'h8000_0003, 32'h5a5a_a5a5
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [VEC_W-1:0] src_a_i = '0, src_b_i = '0;
  logic [1:0] size_i = '0;
  logic signed_i = 1'b0;
  logic [2:0] pred_i = '0;
  logic [MASK_W-1:0] qual_mask_i = '0;
  logic valid_o;
  logic [MASK_W-1:0] mask_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng;

  always #10 clk_i = ~clk_i;

  vcmp_mask_unit #(.VEC_W(VEC_W)) dut_i (.*);

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [MASK_W-1:0] model(
      logic [VEC_W-1:0] a, logic [VEC_W-1:0] b, int sz, logic sgn,
      int pr, logic [MASK_W-1:0] q);
    logic [MASK_W-1:0] m = '0;
    int w = 8 << sz;
    int n = VEC_W / w;
    for (int i = 0; i < n; i++) begin
      logic [63:0] ea = '0, eb = '0;
      logic signed [65:0] xa, xb;
      logic r;
      for (int k = 0; k < w; k++) begin
        ea[k] = a[i*w+k];
        eb[k] = b[i*w+k];
      end
      xa = $signed({2'b00, ea});
      xb = $signed({2'b00, eb});
      if (sgn && ea[w-1]) xa = xa - (66'sd1 <<< w);
      if (sgn && eb[w-1]) xb = xb - (66'sd1 <<< w);
      case (pr)
        0: r = (xa == xb);
        1: r = (xa < xb);
        2: r = (xa <= xb);
        3: r = 1'b0;
        4: r = (xa != xb);
        5: r = (xa >= xb);
        6: r = (xa > xb);
        default: r = 1'b1;
      endcase
      m[i] = r & q[i];
    end
    return m;
  endfunction

  task automatic check(string req, logic [MASK_W-1:0] act, logic [MASK_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
                        int sz, logic sgn, int pr, logic [MASK_W-1:0] q);
    logic [MASK_W-1:0] exp;
    exp = model(a, b, sz, sgn, pr, q);
    @(negedge clk_i);
    src_a_i = a; src_b_i = b; size_i = 2'(sz); signed_i = sgn;
    pred_i = 3'(pr); qual_mask_i = q; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, mask_o, exp);
    check("R8 valid high", {63'd0, valid_o}, 64'd1);
    // disturb inputs: result must hold
    src_a_i = ~a; qual_mask_i = '1; pred_i = 3'd7;
    @(negedge clk_i);
    check("R8 valid low", {63'd0, valid_o}, 64'd0);
    check("R9 hold", mask_o, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] a, b;
    logic [MASK_W-1:0] q;
    repeat (3) @(negedge clk_i);
    check("R9 reset mask", mask_o, '0);
    check("R9 reset valid", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;

    foreach (SEEDS[s]) begin
      rng = SEEDS[s];
      for (int c = 0; c < VEC_W / 32; c++) begin
        rng = step(rng); a[c*32 +: 32] = rng;
        rng = step(rng); b[c*32 +: 32] = rng;
      end
      // force some equal 64-bit chunks so equality occurs at every width
      for (int c = 0; c < VEC_W / 64; c++) begin
        rng = step(rng);
        if (rng[1:0] == 2'b00) b[c*64 +: 64] = a[c*64 +: 64];
        else if (rng[1:0] == 2'b01) b[c*64 +: 16] = a[c*64 +: 16];
      end
      rng = step(rng); q[31:0] = rng;
      rng = step(rng); q[63:32] = rng;
      if (s % 2 == 0) q = '1;
      for (int sz = 0; sz < 4; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int pr = 0; pr < 8; pr++)
            run_op((pr == 3 || pr == 7) ? "R2" : (sg ? "R3" : "R1"),
                   a, b, sz, 1'(sg), pr, q);
    end

    // R5: only lane 5 of 32-bit lanes equal
    a = '1; b = '0; a[5*32 +: 32] = 32'h0;
    run_op("R5 placement", a, b, 2, 1'b0, 0, '1);
    check("R5 bit5", mask_o, 64'h20);
    // R4: lane counts via always-true
    run_op("R4 size64", a, b, 3, 1'b0, 7, '1);
    check("R4 count64", mask_o, 64'hFF);
    run_op("R4 size8", a, b, 0, 1'b0, 7, '1);
    check("R4 count8", mask_o, '1);
    // R6: unused upper bits with 16-bit lanes
    run_op("R6 upper", a, b, 1, 1'b0, 7, '1);
    check("R6 upper zero", mask_o, 64'h0000_0000_FFFF_FFFF);
    // R7: qualifier all clear
    run_op("R7 qual zero", a, b, 0, 1'b0, 7, '0);
    check("R7 qual zero out", mask_o, '0);
    // R3: byte 0x80 vs 0x7f
    a = '0; b = '0; a[7:0] = 8'h80; b[7:0] = 8'h7f;
    run_op("R3 signed lt", a, b, 0, 1'b1, 1, '1);
    check("R3 signed bit0", {63'd0, mask_o[0]}, 64'd1);
    run_op("R3 unsigned gt", a, b, 0, 1'b0, 6, '1);
    check("R3 unsigned bit0", {63'd0, mask_o[0]}, 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule